// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM with Burst Sequencer

This block is a synthesizable model of a single-port synchronous SRAM whose read data flows straight from the array to the outputs. The address and command are registered on a rising clock edge. The word addressed at that edge then appears on the outputs during the cycle that follows. Write data arrives one enabled clock after its command and address, and it is committed at that edge. Because of this, reads and writes can follow each other on consecutive cycles in any mix, with no idle cycle between them.

An advance/load control either loads a fresh external address or steps a two-bit burst counter. The burst counter walks the four words that share the upper address bits. A strap selects linear order (add modulo four) or interleaved order (XOR with a running count). An active-low clock enable stalls the whole interface. Three chip selects decide, at each load, whether the device takes part. Byte-lane write strobes mask individual lanes of a write. The tri-state data bus is split into `din`, `dout` and `dout_oe`.

Top module: `ft_sync_sram`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to the deselected state, and `dout_oe` is low in the following cycle.
- R2: At an edge where `clk_en_n` is high, nothing is sampled and no state changes. No write is committed, `dout` and `dout_oe` keep their values, and the pending command continues after the stall.
- R3: A load (`adv_ld_n` low) selects the device only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Any other combination at a load deselects the device, and `dout_oe` is low in the next cycle.
- R4: A load with `wr_n` high starts a read of `addr`, and a load with `wr_n` low starts a write to `addr`. An advance (`adv_ld_n` high) steps the burst count by one, wrapping after four, and repeats the current read or write type. Chip selects are ignored on an advance.
- R5: An advance issued while deselected leaves the device deselected, performs no access and keeps `dout_oe` low.
- R6: With `burst_mode`=0 (linear), the n-th access of a burst uses low address bits (a+n) mod 4, where a is the loaded value of `addr[1:0]`. The upper address bits stay unchanged.
- R7: With `burst_mode`=1 (interleaved), the n-th access uses low address bits a XOR n. The upper address bits stay unchanged.
- R8: The write data for a write access is taken from `din` at the next enabled edge. Lane i occupies bits [9i+8:9i] and is written only if `lane_wr_n[i]` was low at the edge that issued the access.
- R9: During the cycle after a read access is issued, `dout` shows the stored word at the accessed address. This includes a word written by the access just before it.
- R10: `dout_oe` is high only in a read cycle while `out_en_n` is low. It follows `out_en_n` without waiting for a clock. It is low during write data cycles, while deselected, and in the cycle after a deselect, whatever the value of `out_en_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high stalls the interface |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| adv_ld_n | input | 1 | Low loads a new address, high advances the burst |
| wr_n | input | 1 | Write command, active low, sampled on a load |
| lane_wr_n | input | LANES (2) | Per-lane write strobes, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| burst_mode | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| addr | input | AW (6) | Word address |
| din | input | LANES*LANE_W (18) | Write data |
| dout | output | LANES*LANE_W (18) | Read data |
| dout_oe | output | 1 | High when the data bus would be driven |

## Verification
On every cycle, the assertions check several properties: that a stall freezes the command state and the read data, that a deselecting load or an advance while deselected leaves the device idle, that a write command turns the outputs off in its data cycle, and that the burst counter clears on a load and steps by one on each active advance. Other behaviour only shows up in the bench's sweeps against a shadow memory. That includes the exact linear and interleaved address sequences, the masking of byte lanes, a write followed at once by a read of the same word, the full decode of the chip selects, and the way the output enable follows `out_en_n` between edges.

// File: rtl/sram_pkg.sv
// Package: shared command state type for the flow-through SRAM.
package sram_pkg;
    // Command carried by the current access cycle.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/sram_ctrl.sv
// sram_ctrl: decodes load/advance commands into the current access type
// and latches the active-high lane write mask. Assumes `step` is the
// qualified clock enable and `sel` the already combined chip selects.
module sram_ctrl
    import sram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             sel,
    input  logic             adv_ld_n,
    input  logic             wr_n,
    input  logic [LANES-1:0] lane_wr_n,
    output op_e              op,
    output logic [LANES-1:0] lane_wr
);
    op_e              op_q;
    logic [LANES-1:0] lane_q;

    // Command register: load picks read/write/idle, advance repeats the type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_IDLE;
            lane_q <= '0;
        end else if (step) begin
            if (!adv_ld_n) begin
                if (sel) op_q <= wr_n ? OP_READ : OP_WRITE;
                else     op_q <= OP_IDLE;
            end
            lane_q <= ~lane_wr_n;
        end
    end

    assign op      = op_q;
    assign lane_wr = lane_q;

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(op_q) && $stable(lane_q)); // R2
    AST_DESEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !adv_ld_n && !sel) |=> op_q == OP_IDLE); // R3
    AST_IDLE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && adv_ld_n && op_q == OP_IDLE) |=> op_q == OP_IDLE); // R5
endmodule

// File: rtl/sram_burst.sv
// sram_burst: address register plus two-bit burst counter. Produces the
// word address of the current access in linear or interleaved order.
// Assumes AW >= 3 and that `active` is low while deselected.
module sram_burst #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          load,
    input  logic          active,
    input  logic          mode,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] cur_addr
);
    localparam int HI_W = AW - 2;

    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic [1:0]    low;

    // Base/count register: load clears the count, active advance steps it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (step) begin
            if (load) begin
                base_q <= addr_in;
                cnt_q  <= 2'd0;
            end else if (active) begin
                cnt_q  <= cnt_q + 2'd1;
            end
        end
    end

    // Low-bit sequence: add for linear order, XOR for interleaved order.
    always_comb begin
        low      = mode ? (base_q[1:0] ^ cnt_q) : (base_q[1:0] + cnt_q);
        cur_addr = {base_q[AW-1:2], low};
    end

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && load) |=> cnt_q == 2'd0); // R4
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && active) |=> cnt_q == 2'($past(cnt_q) + 2'd1)); // R4
    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])); // R6
    localparam logic [HI_W-1:0] HI_ZERO = '0;
    AST_LOAD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (step && load) |=> (cur_addr[AW-1:2] ^ $past(addr_in[AW-1:2])) == HI_ZERO); // R4
endmodule

// File: rtl/sram_array.sv
// sram_array: byte-lane storage, one bank per lane. A write updates the
// enabled lanes of waddr at the clock edge; reads are combinational.
// Assumes no reset of the contents.
module sram_array #(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [LANES-1:0]        lane_en,
    input  logic [AW-1:0]           waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [AW-1:0]           raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        // Lane write: store this lane's slice when enabled.
        always_ff @(posedge clk) begin
            if (we && lane_en[g]) bank[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = bank[raddr];
    end
endmodule

// File: rtl/ft_sync_sram.sv
// ft_sync_sram: flow-through synchronous SRAM with burst sequencing and
// write data one clock after its command. Assumes the tri-state bus is
// built outside from dout/dout_oe and that din is valid at enabled edges.
module ft_sync_sram
    import sram_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    adv_ld_n,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    out_en_n,
    input  logic                    burst_mode,
    input  logic [AW-1:0]           addr,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_oe
);
    localparam int DW = LANES * LANE_W;

    logic             step;
    logic             sel;
    op_e              op;
    logic [LANES-1:0] lane_wr;
    logic [AW-1:0]    cur_addr;
    logic             commit;
    logic [DW-1:0]    rdata;

    // Qualifiers: clock enable and the three-way chip select decode.
    always_comb begin
        step   = !clk_en_n;
        sel    = !cs1_n && cs2 && !cs3_n;
        commit = step && (op == OP_WRITE);
    end

    sram_ctrl #(.LANES(LANES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .sel      (sel),
        .adv_ld_n (adv_ld_n),
        .wr_n     (wr_n),
        .lane_wr_n(lane_wr_n),
        .op       (op),
        .lane_wr  (lane_wr)
    );

    sram_burst #(.AW(AW)) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .load    (!adv_ld_n),
        .active  (op != OP_IDLE),
        .mode    (burst_mode),
        .addr_in (addr),
        .cur_addr(cur_addr)
    );

    sram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk    (clk),
        .we     (commit),
        .lane_en(lane_wr),
        .waddr  (cur_addr),
        .wdata  (din),
        .raddr  (cur_addr),
        .rdata  (rdata)
    );

    // Output stage: data flows through; drive only on reads with enable low.
    always_comb begin
        dout    = rdata;
        dout_oe = (op == OP_READ) && !out_en_n;
    end

    AST_WRITE_PHASE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !adv_ld_n && sel && !wr_n) |=> !dout_oe); // R10
    AST_DESEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !adv_ld_n && !sel) |=> !dout_oe); // R3
    AST_STALL_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(dout)); // R2
    AST_RESET_OFF: assert property (@(posedge clk)
        !rst_n |=> !dout_oe); // R1
endmodule

// File: tb/ft_sync_sram_tb.sv
module ft_sync_sram_tb;
    localparam int AW = 6, LANES = 2, LANE_W = 9, DW = 18, DEPTH = 64;

    logic clk = 0, rst_n = 0, clk_en_n = 1, cs1_n = 1, cs2 = 0, cs3_n = 1;
    logic adv_ld_n = 1, wr_n = 1, out_en_n = 0, burst_mode = 0;
    logic [LANES-1:0] lane_wr_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_oe;

    int n_chk = 0, n_fail = 0;

    // Shadow model: 0 idle, 1 read, 2 write.
    int m_op = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0] m_n = '0;
    logic [LANES-1:0] m_strb = '0;
    logic [DW-1:0] exp_mem [DEPTH];

    always #2 clk = ~clk;

    ft_sync_sram #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs1_n(cs1_n), .cs2(cs2),
        .cs3_n(cs3_n), .adv_ld_n(adv_ld_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
        .out_en_n(out_en_n), .burst_mode(burst_mode), .addr(addr), .din(din),
        .dout(dout), .dout_oe(dout_oe)
    );

    function automatic logic [AW-1:0] m_addr();
        logic [1:0] lo;
        lo = burst_mode ? (m_base[1:0] ^ m_n) : 2'(m_base[1:0] + m_n);
        return {m_base[AW-1:2], lo};
    endfunction

    function automatic logic [DW-1:0] pat(int a);
        return DW'(a * 4099 + 17);
    endfunction

    // One clock: update the model at the edge, return at the falling edge.
    task automatic tick();
        @(posedge clk);
        if (!rst_n) begin
            m_op = 0;
        end else if (!clk_en_n) begin
            if (m_op == 2) begin
                logic [AW-1:0] wa = m_addr();
                for (int i = 0; i < LANES; i++)
                    if (m_strb[i]) exp_mem[wa][i*LANE_W +: LANE_W] = din[i*LANE_W +: LANE_W];
            end
            if (!adv_ld_n) begin
                if (!cs1_n && cs2 && !cs3_n) begin
                    m_op = wr_n ? 1 : 2;
                    m_base = addr;
                    m_n = 2'd0;
                end else m_op = 0;
            end else if (m_op != 0) m_n = m_n + 2'd1;
            m_strb = ~lane_wr_n;
        end
        @(negedge clk);
    endtask

    task automatic chk(string tag);
        logic exp_oe;
        logic [DW-1:0] exp_d;
        exp_oe = (m_op == 1) && !out_en_n;
        n_chk++;
        if (dout_oe !== exp_oe) begin
            n_fail++;
            $display("FAIL %s: dout_oe actual %b expected %b", tag, dout_oe, exp_oe);
        end else if (m_op == 1) begin
            exp_d = exp_mem[m_addr()];
            if (dout !== exp_d) begin
                n_fail++;
                $display("FAIL %s: dout actual %h expected %h", tag, dout, exp_d);
            end
        end
    endtask

    task automatic t_load(logic w, logic [AW-1:0] a, logic [LANES-1:0] strb_n, logic [DW-1:0] d);
        clk_en_n = 0; adv_ld_n = 0; wr_n = !w; addr = a; lane_wr_n = strb_n; din = d;
        tick();
    endtask

    task automatic t_adv(logic [LANES-1:0] strb_n, logic [DW-1:0] d);
        clk_en_n = 0; adv_ld_n = 1; lane_wr_n = strb_n; din = d; addr = ~addr;
        tick();
    endtask

    task automatic t_desel(logic [DW-1:0] d);
        clk_en_n = 0; adv_ld_n = 0; cs1_n = 1; din = d;
        tick();
        cs1_n = 0;
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 'x;
        // R1: reset state
        tick(); tick();
        chk("R1");
        rst_n = 1; cs1_n = 0; cs2 = 1; cs3_n = 0;

        // R8: fill every word back to back, data one clock behind each command
        for (int a = 0; a < DEPTH; a++) begin
            t_load(1, AW'(a), 2'b00, pat(a - 1));
            chk("R8");
        end
        t_desel(pat(DEPTH - 1));
        chk("R10");

        // R9: read back every word
        for (int a = 0; a < DEPTH; a++) begin
            t_load(0, AW'(a), 2'b11, '0);
            chk("R9");
        end

        // R6 / R7: bursts from every start offset, both orders, with wrap
        for (int md = 0; md < 2; md++) begin
            burst_mode = md[0];
            for (int s = 0; s < 8; s++) begin
                t_load(0, AW'(16 + 4 * (s / 4) * 6 + (s % 4)), 2'b11, '0);
                chk(md ? "R7" : "R6");
                for (int k = 0; k < 4; k++) begin
                    t_adv(2'b11, '0);
                    chk(md ? "R7" : "R6");
                end
            end
        end

        // R8: every lane strobe combination, then read at once (R9)
        burst_mode = 0;
        for (int sb = 0; sb < 4; sb++) begin
            t_load(1, AW'(5), 2'(sb), '0);
            chk("R10");
            t_load(0, AW'(5), 2'b11, 18'h2AAAA ^ DW'(sb * 777));
            chk("R8");
        end

        // R4 / R7: interleaved write burst with a masked last beat
        burst_mode = 1;
        t_load(1, AW'(30), 2'b00, '0);
        chk("R4");
        t_adv(2'b00, 18'h11111);
        chk("R10");
        t_adv(2'b00, 18'h22222);
        chk("R10");
        t_adv(2'b10, 18'h33333);
        chk("R10");
        t_load(0, AW'(28), 2'b11, 18'h3C3C3);
        chk("R9");
        for (int a = 28; a < 32; a++) begin
            t_load(0, AW'(a), 2'b11, '0);
            chk("R4");
        end

        // R3 / R5: every chip select combination, then an advance
        burst_mode = 0;
        for (int c = 0; c < 8; c++) begin
            {cs1_n, cs2, cs3_n} = 3'(c);
            t_load(0, AW'(9), 2'b11, '0);
            chk("R3");
            t_adv(2'b11, '0);
            chk("R5");
        end
        cs1_n = 0; cs2 = 1; cs3_n = 0;

        // R2: stall during a read burst, then continue
        t_load(0, AW'(12), 2'b11, '0);
        chk("R2");
        clk_en_n = 1; adv_ld_n = 0; wr_n = 0; addr = AW'(40); din = 18'h15555;
        tick(); chk("R2");
        tick(); chk("R2");
        t_adv(2'b11, '0);
        chk("R2");
        // R2: stall inside a write data phase
        t_load(1, AW'(20), 2'b00, '0);
        clk_en_n = 1; din = 18'h0F0F0;
        tick(); chk("R2");
        t_load(0, AW'(20), 2'b11, 18'h12345);
        chk("R2");

        // R10: output enable acts between edges
        t_load(0, AW'(7), 2'b11, '0);
        out_en_n = 1; #0.5; chk("R10");
        out_en_n = 0; #0.5; chk("R10");
        t_desel('0);
        chk("R10");
        t_load(0, AW'(3), 2'b11, '0);
        chk("R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule